// File: doc/BRIEF.md
# Pixel Word Serializer with Cursor Overlay

This block turns a line of 16-bit display words into a serial pixel stream, one pixel per clock, most significant bit first. A line begins when horizontal blank falls. For every output word the serializer fetches a word from a show-ahead display buffer, XORs it with an inverse-video mask, and optionally expands it. In half-resolution mode one fetched word covers two output words: the high byte comes first, then the low byte, and every bit is repeated twice. A 32-bit cursor pattern is XORed over two consecutive output words, starting at a programmable word index.

The inverse and half-resolution settings are sampled from the mode inputs only on the rising edge of horizontal sync, so they stay fixed for a whole line. The line ends after a parameterized number of visible words, 38 by default, and an end-of-line flag is raised. A rising edge of horizontal sync stops any line in progress. If the buffer is empty when a word is needed, the word shows the inverse mask alone and no read is issued.

Top module: `px_serializer`

## Requirements
- R1: After reset, and while no line is in progress, `pix_out` is 0. A cycle in which `hblank` is 0, `hblank` was 1 on the previous clock edge, and `hsync` is 0 starts a line. The first pixel of word 0 appears on `pix_out` after the next clock edge.
- R2: Each output word takes exactly 16 clocks. Its bit 15 is sent first and bit 0 last. Words follow each other with no gap.
- R3: In half mode, a fetched word produces two output words. The first is the high byte with each bit doubled, so source bit 7 drives output bits 15 and 14 and source bit 0 drives bits 1 and 0. The second is the low byte, doubled the same way. Only the first of the pair issues a buffer read.
- R4: When inverse mode is latched, each fetched word is XORed with 16'hFFFF before expansion. Otherwise it passes unchanged.
- R5: The output word whose index equals `cur_idx` is XORed with `cur_data[31:16]`. The word at index `cur_idx`+1 is XORed with `cur_data[15:0]`. Indices count output words from 0 within the line.
- R6: `mode_inv` and `mode_half` are sampled only on the clock edge where `hsync` rises. Changes to them at any other time do not affect the line.
- R7: When a fetch is needed while `buf_empty` is 1, `buf_rd` stays 0. The source word is then taken to be the inverse mask alone (all ones or all zeros), and the cursor is still applied.
- R8: After the last bit of word VIS_WORDS-1, `pix_out` returns to 0 and `line_done` becomes 1. It stays 1 until the next `hsync` rise or the next line start.
- R9: A rising `hsync` aborts a line in progress. On the next edge `pix_out` is 0 and `line_done` is 0, and no further reads are issued.
- R10: `buf_rd` is a single-cycle strobe issued in the cycle before the word is shifted out. `buf_data` is taken in that same cycle. A full line issues exactly VIS_WORDS reads in normal mode and ceil(VIS_WORDS/2) in half mode, or fewer when the buffer runs empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one pixel per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| hblank | input | 1 | Horizontal blank; its falling edge starts a line |
| hsync | input | 1 | Horizontal sync; its rising edge latches mode and aborts a line |
| mode_inv | input | 1 | Requested inverse-video setting |
| mode_half | input | 1 | Requested half-resolution setting |
| buf_data | input | 16 | Head word of the display buffer (show-ahead) |
| buf_empty | input | 1 | Display buffer holds no word |
| buf_rd | output | 1 | Pops the head word of the buffer |
| cur_idx | input | 6 | Output word index of the cursor's first word |
| cur_data | input | 32 | Cursor pattern; upper half first |
| pix_out | output | 1 | Serial pixel |
| line_done | output | 1 | Visible words of the line have all been sent |

## Verification
The assertions assume that the buffer is show-ahead: the head word is valid whenever `buf_empty` is 0, and it advances only on `buf_rd`. They also assume that `hsync` and `hblank` are single-bit levels synchronous to `clk`. The bench models the buffer as an array that pops exactly on `buf_rd` and returns a junk value when empty, so any use of data during an underrun shows up. It drives `hsync` for one cycle and holds `hblank` low until the line ends. It then inverts the mode inputs right after sync, so the latching rule is exercised on every line.

// File: rtl/px_pkg.sv
package px_pkg;
  localparam int WORD_W  = 16;
  localparam int HALF_W  = WORD_W / 2;
  localparam int CURS_W  = 2 * WORD_W;
  localparam int BIT_W   = $clog2(WORD_W);

  // Repeat every bit of a half word, giving a full word.
  function automatic logic [WORD_W-1:0] dbl_bits(input logic [HALF_W-1:0] b);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < HALF_W; i++) begin
      r[2*i]   = b[i];
      r[2*i+1] = b[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/px_edges.sv
module px_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic hblank,
  input  logic hsync,
  input  logic mode_inv,
  input  logic mode_half,
  output logic start,
  output logic hs_rise,
  output logic inv_l,
  output logic half_l
);
  logic hblank_q, hsync_q;
  logic inv_n, half_n;

  assign hs_rise = hsync & ~hsync_q;
  assign start   = hblank_q & ~hblank & ~hsync;

  always_comb begin
    inv_n  = inv_l;
    half_n = half_l;
    if (hs_rise) begin
      inv_n  = mode_inv;
      half_n = mode_half;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hblank_q <= 1'b1;
      hsync_q  <= 1'b0;
      inv_l    <= 1'b0;
      half_l   <= 1'b0;
    end else begin
      hblank_q <= hblank;
      hsync_q  <= hsync;
      inv_l    <= inv_n;
      half_l   <= half_n;
    end
  end
endmodule

// File: rtl/px_word_build.sv
module px_word_build
  import px_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [WORD_W-1:0] fetch_data,
  input  logic              fetch_ok,
  input  logic              inv,
  input  logic              half,
  input  logic              second,
  input  logic [HALF_W-1:0] lo_held,
  input  logic [IDX_W-1:0]  nidx,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [CURS_W-1:0] cur_data,
  output logic [WORD_W-1:0] word,
  output logic [HALF_W-1:0] lo_new
);
  localparam logic [IDX_W:0] ONE = 1;

  logic [WORD_W-1:0] mask, src, base, curs;
  logic              hit_hi, hit_lo;

  assign mask   = {WORD_W{inv}};
  assign src    = fetch_ok ? (fetch_data ^ mask) : mask;
  assign lo_new = src[HALF_W-1:0];
  assign hit_hi = (nidx == cur_idx);
  assign hit_lo = ({1'b0, nidx} == ({1'b0, cur_idx} + ONE));

  always_comb begin
    if (!half)       base = src;
    else if (second) base = dbl_bits(lo_held);
    else             base = dbl_bits(src[WORD_W-1:HALF_W]);
    if (hit_hi)      curs = cur_data[CURS_W-1:WORD_W];
    else if (hit_lo) curs = cur_data[WORD_W-1:0];
    else             curs = '0;
    word = base ^ curs;
  end
endmodule

// File: rtl/px_serial_ctrl.sv
module px_serial_ctrl
  import px_pkg::*;
#(
  parameter int VIS_WORDS = 38,
  parameter int IDX_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hs_rise,
  input  logic              half_l,
  input  logic              inv_l,
  input  logic              buf_empty,
  input  logic [WORD_W-1:0] word_in,
  input  logic [HALF_W-1:0] lo_new,
  output logic [IDX_W-1:0]  nidx,
  output logic              second_nx,
  output logic              fetch_ok,
  output logic              buf_rd,
  output logic [HALF_W-1:0] lo_held,
  output logic              pix_out,
  output logic              line_done
);
  localparam logic [IDX_W-1:0] LAST     = IDX_W'(VIS_WORDS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  logic              active_q, active_n;
  logic              second_q, second_n;
  logic              done_n;
  logic [BIT_W-1:0]  bcnt_q, bcnt_n;
  logic [IDX_W-1:0]  widx_q, widx_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic [HALF_W-1:0] lo_n;
  logic              wrap, load, fetch;

  assign wrap      = active_q && (bcnt_q == BIT_LAST);
  assign load      = !hs_rise && (start || (wrap && (widx_q != LAST)));
  assign nidx      = start ? '0 : widx_q + 1'b1;
  assign second_nx = half_l && !start && !second_q;
  assign fetch     = load && !second_nx;
  assign fetch_ok  = fetch && !buf_empty;
  assign buf_rd    = fetch_ok;
  assign pix_out   = active_q & sh_q[WORD_W-1];

  always_comb begin
    active_n = active_q;
    second_n = second_q;
    done_n   = line_done;
    bcnt_n   = bcnt_q;
    widx_n   = widx_q;
    sh_n     = sh_q;
    lo_n     = lo_held;
    if (hs_rise) begin
      active_n = 1'b0;
      second_n = 1'b0;
      done_n   = 1'b0;
    end else if (load) begin
      active_n = 1'b1;
      sh_n     = word_in;
      bcnt_n   = '0;
      widx_n   = nidx;
      second_n = second_nx;
      if (fetch) lo_n = lo_new;
      if (start) done_n = 1'b0;
    end else if (wrap) begin
      active_n = 1'b0;
      done_n   = 1'b1;
    end else if (active_q) begin
      sh_n   = {sh_q[WORD_W-2:0], 1'b0};
      bcnt_n = bcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      second_q  <= 1'b0;
      line_done <= 1'b0;
      bcnt_q    <= '0;
      widx_q    <= '0;
      sh_q      <= '0;
      lo_held   <= '0;
    end else begin
      active_q  <= active_n;
      second_q  <= second_n;
      line_done <= done_n;
      bcnt_q    <= bcnt_n;
      widx_q    <= widx_n;
      sh_q      <= sh_n;
      lo_held   <= lo_n;
    end
  end

  // R1
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hs_rise) |=> (active_q && bcnt_q == '0 && widx_q == '0));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> ($stable(half_l) && $stable(inv_l)));

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_done) |-> $past(active_q));

  // R10
  rd_then_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd |=> (active_q && bcnt_q == '0));

  // R9
  sync_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> (!active_q && !line_done));
endmodule

// File: rtl/px_serializer.sv
module px_serializer
  import px_pkg::*;
#(
  parameter  int VIS_WORDS = 38,
  localparam int IDX_W     = $clog2(VIS_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hblank,
  input  logic              hsync,
  input  logic              mode_inv,
  input  logic              mode_half,
  input  logic [15:0]       buf_data,
  input  logic              buf_empty,
  output logic              buf_rd,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [31:0]       cur_data,
  output logic              pix_out,
  output logic              line_done
);
  logic              start, hs_rise, inv_l, half_l;
  logic [IDX_W-1:0]  nidx;
  logic              second_nx, fetch_ok;
  logic [HALF_W-1:0] lo_held, lo_new;
  logic [WORD_W-1:0] word;

  px_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .hblank   (hblank),
    .hsync    (hsync),
    .mode_inv (mode_inv),
    .mode_half(mode_half),
    .start    (start),
    .hs_rise  (hs_rise),
    .inv_l    (inv_l),
    .half_l   (half_l)
  );

  px_word_build #(.IDX_W(IDX_W)) u_build (
    .fetch_data(buf_data),
    .fetch_ok  (fetch_ok),
    .inv       (inv_l),
    .half      (half_l),
    .second    (second_nx),
    .lo_held   (lo_held),
    .nidx      (nidx),
    .cur_idx   (cur_idx),
    .cur_data  (cur_data),
    .word      (word),
    .lo_new    (lo_new)
  );

  px_serial_ctrl #(.VIS_WORDS(VIS_WORDS), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .hs_rise  (hs_rise),
    .half_l   (half_l),
    .inv_l    (inv_l),
    .buf_empty(buf_empty),
    .word_in  (word),
    .lo_new   (lo_new),
    .nidx     (nidx),
    .second_nx(second_nx),
    .fetch_ok (fetch_ok),
    .buf_rd   (buf_rd),
    .lo_held  (lo_held),
    .pix_out  (pix_out),
    .line_done(line_done)
  );
endmodule

// File: tb/px_serializer_tb.sv
module px_serializer_tb;
  localparam int VIS = 38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hblank = 1'b1, hsync = 1'b0;
  logic        mode_inv = 1'b0, mode_half = 1'b0;
  logic [15:0] buf_data;
  logic        buf_empty, buf_rd;
  logic [5:0]  cur_idx = '0;
  logic [31:0] cur_data = '0;
  logic        pix_out, line_done;

  int checks = 0, errors = 0;

  logic [15:0] fmem [0:63];
  int          fcount = 0;
  int          frd = 0;
  int          rd_cnt = 0;
  logic        fifo_clr = 1'b0;

  always #2 clk = ~clk;

  assign buf_empty = (frd >= fcount);
  assign buf_data  = buf_empty ? 16'hDEAD : fmem[frd[5:0]];

  always @(posedge clk) begin
    if (fifo_clr) begin
      frd    <= 0;
      rd_cnt <= 0;
    end else if (buf_rd) begin
      frd    <= frd + 1;
      rd_cnt <= rd_cnt + 1;
    end
  end

  px_serializer #(.VIS_WORDS(VIS)) u_dut (
    .clk(clk), .rst_n(rst_n), .hblank(hblank), .hsync(hsync),
    .mode_inv(mode_inv), .mode_half(mode_half),
    .buf_data(buf_data), .buf_empty(buf_empty), .buf_rd(buf_rd),
    .cur_idx(cur_idx), .cur_data(cur_data),
    .pix_out(pix_out), .line_done(line_done)
  );

  // {inv, half, cursor index, cursor data, words in buffer, seed}
  localparam logic [61:0] VEC [0:7] = '{
    {1'b0, 1'b0, 6'd5,  32'hA5A5_0F0F, 6'd38, 16'h1234},
    {1'b1, 1'b0, 6'd0,  32'hFFFF_0000, 6'd38, 16'hBEEF},
    {1'b0, 1'b1, 6'd3,  32'h1234_8001, 6'd19, 16'h0042},
    {1'b1, 1'b1, 6'd37, 32'hC3C3_3C3C, 6'd19, 16'h7777},
    {1'b0, 1'b0, 6'd10, 32'h0000_0000, 6'd12, 16'h5555},
    {1'b1, 1'b1, 6'd20, 32'hF0F0_0F0F, 6'd7,  16'h0101},
    {1'b0, 1'b0, 6'd36, 32'hDEAD_BEEF, 6'd38, 16'h0000},
    {1'b0, 1'b1, 6'd0,  32'h0000_FFFF, 6'd0,  16'h0000}
  };

  function automatic logic [15:0] gen(input logic [15:0] seed, input int s);
    return seed ^ 16'((s + 1) * 40503);
  endfunction

  function automatic logic [15:0] exp_word(input int k, input bit inv, input bit half,
                                           input int cidx, input logic [31:0] cd,
                                           input int nfill, input logic [15:0] seed);
    logic [15:0] mask, raw, w;
    logic [7:0]  b;
    int          s;
    mask = inv ? 16'hFFFF : 16'h0000;
    s    = half ? k / 2 : k;
    raw  = (s < nfill) ? (gen(seed, s) ^ mask) : mask;
    if (half) begin
      b = (k % 2 == 0) ? raw[15:8] : raw[7:0];
      for (int i = 0; i < 8; i++) begin
        w[2*i]   = b[i];
        w[2*i+1] = b[i];
      end
    end else begin
      w = raw;
    end
    if (k == cidx) w = w ^ cd[31:16];
    else if (k == cidx + 1) w = w ^ cd[15:0];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sync_and_fill(input bit inv, input bit half, input int cidx,
                               input logic [31:0] cd, input int nfill,
                               input logic [15:0] seed);
    @(negedge clk);
    mode_inv  = inv;
    mode_half = half;
    cur_idx   = 6'(cidx);
    cur_data  = cd;
    for (int i = 0; i < 64; i++) fmem[i] = gen(seed, i);
    fcount    = nfill;
    fifo_clr  = 1'b1;
    hblank    = 1'b1;
    hsync     = 1'b1;
    @(negedge clk);
    hsync     = 1'b0;
    fifo_clr  = 1'b0;
    // R6: flip the requested mode after sync; the line must ignore it
    mode_inv  = ~inv;
    mode_half = ~half;
    @(negedge clk);
    chk("R1 idle pixel", {31'd0, pix_out}, 32'd0);
  endtask

  task automatic run_line(input bit inv, input bit half, input int cidx,
                          input logic [31:0] cd, input int nfill,
                          input logic [15:0] seed, input string ftag);
    logic [15:0] got;
    string       t;
    int          need, exp_rd;
    sync_and_fill(inv, half, cidx, cd, nfill, seed);
    hblank = 1'b0;
    for (int k = 0; k < VIS; k++) begin
      got = '0;
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        got = {got[14:0], pix_out};
      end
      if (k == 0 && ftag != "")            t = ftag;
      else if (k == cidx || k == cidx + 1) t = "R5 cursor word";
      else if ((half ? k / 2 : k) >= nfill) t = "R7 underrun word";
      else if (half)                        t = "R3 half word";
      else if (inv)                         t = "R4 inverse word";
      else                                  t = "R2 normal word";
      chk(t, {16'd0, got}, {16'd0, exp_word(k, inv, half, cidx, cd, nfill, seed)});
    end
    @(negedge clk);
    chk("R8 line_done after last word", {31'd0, line_done}, 32'd1);
    chk("R8 pixel idle after line", {31'd0, pix_out}, 32'd0);
    need   = half ? (VIS + 1) / 2 : VIS;
    exp_rd = (nfill < need) ? nfill : need;
    chk("R10 read strobe count", 32'(rd_cnt), 32'(exp_rd));
    hblank = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset pixel", {31'd0, pix_out}, 32'd0);
    chk("R11 reset line_done", {31'd0, line_done}, 32'd0);
    chk("R11 reset buf_rd", {31'd0, buf_rd}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {31'd0, pix_out}, 32'd0);

    for (int v = 0; v < 8; v++) begin
      run_line(VEC[v][61], VEC[v][60], int'(VEC[v][59:54]), VEC[v][53:22],
               int'(VEC[v][21:16]), VEC[v][15:0], (v == 1) ? "R6 latched mode word" : "R1 first word");
    end

    // R9: abort mid-line with hsync, buffer full of ones
    begin
      int bad_pix = 0, bad_rd = 0;
      sync_and_fill(1'b0, 1'b0, 63, 32'd0, 38, 16'h0000);
      for (int i = 0; i < 38; i++) fmem[i] = 16'hFFFF;
      hblank = 1'b0;
      repeat (40) @(negedge clk);
      chk("R9 line running before abort", {31'd0, pix_out}, 32'd1);
      hsync = 1'b1;
      @(negedge clk);
      hsync = 1'b0;
      chk("R9 pixel after abort", {31'd0, pix_out}, 32'd0);
      chk("R9 line_done after abort", {31'd0, line_done}, 32'd0);
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (pix_out) bad_pix++;
        if (buf_rd)  bad_rd++;
      end
      chk("R9 no pixels after abort", 32'(bad_pix), 32'd0);
      chk("R9 no reads after abort", 32'(bad_rd), 32'd0);
      hblank = 1'b1;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule